// File: doc/BRIEF.md
# Dual-Issue Instruction Pair Steering

This block sits between instruction fetch and two execution pipes of an in-order core. Each clock it may take in one 64-bit fetch bundle holding two 32-bit instructions. The left (lower-addressed) instruction occupies bundle bits 31:0 and the right instruction occupies bits 63:32. The block holds the bundle and decides, every cycle, whether to send out none, the left instruction only, or both. Each instruction goes to the integer pipe or the floating-point pipe according to its class. The two instructions go out together only when the left one is integer-class and the right one is floating-point. Both then travel down their pipes side by side.

Instruction fields are laid out as follows: opcode in bits 31:26, first source register in 25:21, second source register in 20:16, and destination register in 15:11. Integer and FP operations draw their register indices from a single 32-entry namespace. A busy bit per register is set when an instruction with that destination issues. It is cleared by either of two writeback ports. Register 0 never becomes busy. An instruction whose sources or destination are busy waits. The block asserts its fetch-ready output only when nothing of the current bundle will remain after the current cycle.

Top module: `pair_issue_steer`

## Requirements
- R1: After reset both issue-valid outputs are low, fetch_ready is high and no register is busy.
- R2: An instruction whose opcode (bits 31:26) equals FP_OPCODE (default 6'h11) is FP-class and issues only on the FP pipe. Every other opcode, including 6'h10 and 6'h12, is integer-class and issues only on the integer pipe, from either slot.
- R3: A held bundle with an integer-class left instruction and an FP-class right instruction, free of hazards, issues both in the same cycle. The left instruction goes on the integer pipe and the right one on the FP pipe.
- R4: The right instruction never issues in a cycle in which the left instruction of its bundle is still held and does not issue.
- R5: If the right instruction is integer-class, it is not paired. It issues on the integer pipe in a later cycle than the left instruction.
- R6: If the left destination is non-zero and the right instruction reads or writes that register, the right instruction does not issue in the same cycle as the left one.
- R7: An issued instruction with a non-zero destination marks that register busy from the next cycle. An instruction whose source or destination register is busy does not issue. It issues in the cycle after a writeback port clears the register.
- R8: Register 0 is never busy, so reading or writing it never stalls issue.
- R9: fetch_ready is high exactly when no half of the held bundle remains after the current cycle. A bundle is taken on a clock edge where fetch_valid and fetch_ready are both high, and it can issue from the next cycle.
- R10: While fetch_ready is low, a presented bundle is ignored. The held instruction stays unchanged and the presented one is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch bundle is presented |
| fetch_bundle | input | 64 | Left instruction in 31:0, right instruction in 63:32 |
| fetch_ready | output | 1 | The block can take a bundle this cycle |
| int_wb_valid | input | 1 | First writeback port clears a busy bit |
| int_wb_reg | input | 5 | Register cleared by the first writeback port |
| fp_wb_valid | input | 1 | Second writeback port clears a busy bit |
| fp_wb_reg | input | 5 | Register cleared by the second writeback port |
| int_issue_valid | output | 1 | An instruction goes to the integer pipe |
| int_issue_instr | output | 32 | Instruction sent to the integer pipe |
| fp_issue_valid | output | 1 | An instruction goes to the FP pipe |
| fp_issue_instr | output | 32 | Instruction sent to the FP pipe |

## Verification
The bench sends bundles of different class combinations and checks what each case separates:
- An integer/FP pair must go out together.
- An integer/integer pair must split across two cycles.
- An FP/FP pair must split across two cycles on the FP pipe.
- Opcodes next to the FP value (6'h10, 6'h12) must be treated as integer-class.

Dependency patterns separate a stall on a busy source from a stall on an intra-bundle dependency. Register-0 operands show that register 0 never stalls. A bundle presented during a stall shows that held state is protected. A queue of expected instructions per pipe confirms order and that nothing extra ever issues.

// File: rtl/steer_pkg.sv
`timescale 1ns/1ps
package steer_pkg;
    localparam int INSTR_W  = 32;
    localparam int NSLOT    = 2;
    localparam int OP_W     = 6;
    localparam int REG_W    = 5;
    localparam int NREGS    = 1 << REG_W;
    localparam int BUNDLE_W = INSTR_W * NSLOT;

    localparam int OP_LSB  = INSTR_W - OP_W;
    localparam int RS1_LSB = OP_LSB - REG_W;
    localparam int RS2_LSB = RS1_LSB - REG_W;
    localparam int RD_LSB  = RS2_LSB - REG_W;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef struct packed {
        logic     is_fp;
        reg_idx_t src_a;
        reg_idx_t src_b;
        reg_idx_t dst;
    } slot_info_t;

    typedef struct packed {
        logic [NSLOT-1:0]              pend;
        logic [NSLOT-1:0][INSTR_W-1:0] slot;
    } hold_t;
endpackage

// File: rtl/steer_slot_decode.sv
`timescale 1ns/1ps
module steer_slot_decode
    import steer_pkg::*;
#(
    parameter logic [OP_W-1:0] FP_OPCODE = 6'h11
) (
    input  logic [INSTR_W-1:0] instr,
    output slot_info_t         info
);
    always_comb begin
        info.is_fp = (instr[OP_LSB +: OP_W] == FP_OPCODE);
        info.src_a = instr[RS1_LSB +: REG_W];
        info.src_b = instr[RS2_LSB +: REG_W];
        info.dst   = instr[RD_LSB +: REG_W];
    end
endmodule

// File: rtl/steer_hazard.sv
`timescale 1ns/1ps
module steer_hazard
    import steer_pkg::*;
(
    input  slot_info_t       info,
    input  logic [NREGS-1:0] busy,
    output logic             blocked
);
    always_comb begin
        blocked = busy[info.src_a] | busy[info.src_b] | busy[info.dst];
    end
endmodule

// File: rtl/steer_scoreboard.sv
`timescale 1ns/1ps
module steer_scoreboard
    import steer_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0]            set_v,
    input  logic [NPORT-1:0][REG_W-1:0] set_reg,
    input  logic [NPORT-1:0]            clr_v,
    input  logic [NPORT-1:0][REG_W-1:0] clr_reg,
    output logic [NREGS-1:0]            busy_q
);
    logic [NREGS-1:0] busy_d;

    always_comb begin
        busy_d = busy_q;
        for (int p = 0; p < NPORT; p++) begin
            if (clr_v[p]) busy_d[clr_reg[p]] = 1'b0;
        end
        for (int p = 0; p < NPORT; p++) begin
            if (set_v[p]) busy_d[set_reg[p]] = 1'b1;
        end
        busy_d[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end
endmodule

// File: rtl/pair_issue_steer.sv
`timescale 1ns/1ps
module pair_issue_steer
    import steer_pkg::*;
#(
    parameter logic [5:0] FP_OPCODE = 6'h11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_valid,
    input  logic [63:0] fetch_bundle,
    output logic        fetch_ready,
    input  logic        int_wb_valid,
    input  logic [4:0]  int_wb_reg,
    input  logic        fp_wb_valid,
    input  logic [4:0]  fp_wb_reg,
    output logic        int_issue_valid,
    output logic [31:0] int_issue_instr,
    output logic        fp_issue_valid,
    output logic [31:0] fp_issue_instr
);
    hold_t            st_q, st_d;
    slot_info_t       info [NSLOT];
    logic [NSLOT-1:0] blocked;
    logic [NREGS-1:0] busy_q;
    logic             issue_l, issue_r, dep_lr, pair_ok;
    logic [NSLOT-1:0] remain;
    logic [NSLOT-1:0] set_v;
    logic [NSLOT-1:0][REG_W-1:0] set_reg;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        steer_slot_decode #(.FP_OPCODE(FP_OPCODE)) u_dec (
            .instr (st_q.slot[s]),
            .info  (info[s])
        );
        steer_hazard u_haz (
            .info    (info[s]),
            .busy    (busy_q),
            .blocked (blocked[s])
        );
    end

    steer_scoreboard #(.NPORT(NSLOT)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_v   (set_v),
        .set_reg (set_reg),
        .clr_v   ({fp_wb_valid, int_wb_valid}),
        .clr_reg ({fp_wb_reg, int_wb_reg}),
        .busy_q  (busy_q)
    );

    always_comb begin
        dep_lr  = (info[0].dst != '0) &&
                  ((info[1].src_a == info[0].dst) ||
                   (info[1].src_b == info[0].dst) ||
                   (info[1].dst   == info[0].dst));
        pair_ok = !info[0].is_fp && info[1].is_fp && !dep_lr;
        issue_l = st_q.pend[0] && !blocked[0];
        issue_r = st_q.pend[1] && !blocked[1] &&
                  (st_q.pend[0] ? (issue_l && pair_ok) : 1'b1);
        remain  = st_q.pend & ~{issue_r, issue_l};
        fetch_ready = (remain == '0);

        st_d      = st_q;
        st_d.pend = remain;
        if (fetch_valid && fetch_ready) begin
            st_d.pend = '1;
            for (int s = 0; s < NSLOT; s++) begin
                st_d.slot[s] = fetch_bundle[s*INSTR_W +: INSTR_W];
            end
        end

        set_v   = {issue_r, issue_l};
        set_reg = {info[1].dst, info[0].dst};

        int_issue_valid = (issue_l && !info[0].is_fp) || (issue_r && !info[1].is_fp);
        int_issue_instr = (issue_l && !info[0].is_fp) ? st_q.slot[0] : st_q.slot[1];
        fp_issue_valid  = (issue_l && info[0].is_fp) || (issue_r && info[1].is_fp);
        fp_issue_instr  = (issue_l && info[0].is_fp) ? st_q.slot[0] : st_q.slot[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/steer_checker.sv
`timescale 1ns/1ps
module steer_checker #(
    parameter logic [5:0] FP_OPCODE = 6'h11
) (
    input logic        clk,
    input logic        rst_n,
    input logic        fetch_ready,
    input logic        int_issue_valid,
    input logic [31:0] int_issue_instr,
    input logic        fp_issue_valid,
    input logic [31:0] fp_issue_instr,
    input logic [31:0] busy,
    input logic [1:0]  pend,
    input logic [31:0] left_instr,
    input logic        issue_l,
    input logic        issue_r
);
    a_r2_fp_pipe_class: assert property (@(posedge clk) disable iff (!rst_n)
        fp_issue_valid |-> (fp_issue_instr[31:26] == FP_OPCODE));

    a_r2_int_pipe_class: assert property (@(posedge clk) disable iff (!rst_n)
        int_issue_valid |-> (int_issue_instr[31:26] != FP_OPCODE));

    a_r4_right_follows_left: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && issue_r) |-> issue_l);

    a_r6_pair_independent: assert property (@(posedge clk) disable iff (!rst_n)
        (int_issue_valid && fp_issue_valid && int_issue_instr[15:11] != 5'd0) |->
        (fp_issue_instr[25:21] != int_issue_instr[15:11] &&
         fp_issue_instr[20:16] != int_issue_instr[15:11] &&
         fp_issue_instr[15:11] != int_issue_instr[15:11]));

    a_r7_int_regs_free: assert property (@(posedge clk) disable iff (!rst_n)
        int_issue_valid |-> (!busy[int_issue_instr[25:21]] &&
                             !busy[int_issue_instr[20:16]] &&
                             !busy[int_issue_instr[15:11]]));

    a_r7_fp_regs_free: assert property (@(posedge clk) disable iff (!rst_n)
        fp_issue_valid |-> (!busy[fp_issue_instr[25:21]] &&
                            !busy[fp_issue_instr[20:16]] &&
                            !busy[fp_issue_instr[15:11]]));

    a_r7_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (int_issue_valid && int_issue_instr[15:11] != 5'd0) |=>
        busy[$past(int_issue_instr[15:11])]);

    a_r8_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy[0]);

    a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == 2'b00) |-> fetch_ready);

    a_r10_left_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !issue_l) |=> $stable(left_instr));
endmodule

bind pair_issue_steer steer_checker #(.FP_OPCODE(FP_OPCODE)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_ready     (fetch_ready),
    .int_issue_valid (int_issue_valid),
    .int_issue_instr (int_issue_instr),
    .fp_issue_valid  (fp_issue_valid),
    .fp_issue_instr  (fp_issue_instr),
    .busy            (busy_q),
    .pend            (st_q.pend),
    .left_instr      (st_q.slot[0]),
    .issue_l         (issue_l),
    .issue_r         (issue_r)
);

// File: tb/pair_issue_steer_test.sv
`timescale 1ns/1ps
module pair_issue_steer_test;
    localparam logic [5:0] FPOP = 6'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_bundle = '0;
    logic        fetch_ready;
    logic        int_wb_valid = 1'b0;
    logic [4:0]  int_wb_reg = '0;
    logic        fp_wb_valid = 1'b0;
    logic [4:0]  fp_wb_reg = '0;
    logic        int_issue_valid, fp_issue_valid;
    logic [31:0] int_issue_instr, fp_issue_instr;

    int checks = 0;
    int errors = 0;
    logic [31:0] q_int [$];
    logic [31:0] q_fp  [$];

    always #4 clk = ~clk;

    pair_issue_steer uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_bundle(fetch_bundle), .fetch_ready(fetch_ready),
        .int_wb_valid(int_wb_valid), .int_wb_reg(int_wb_reg),
        .fp_wb_valid(fp_wb_valid), .fp_wb_reg(fp_wb_reg),
        .int_issue_valid(int_issue_valid), .int_issue_instr(int_issue_instr),
        .fp_issue_valid(fp_issue_valid), .fp_issue_instr(fp_issue_instr)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rd,
                                       input logic [4:0] ra, input logic [4:0] rb);
        return {op, ra, rb, rd, 11'd0};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: every issue must match the next expected item on that pipe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (int_issue_valid) begin
                if (q_int.size() == 0) chk("R10", "unexpected int issue", int_issue_instr, 32'hx);
                else chk("R2", "int pipe order", int_issue_instr, q_int.pop_front());
            end
            if (fp_issue_valid) begin
                if (q_fp.size() == 0) chk("R10", "unexpected fp issue", fp_issue_instr, 32'hx);
                else chk("R2", "fp pipe order", fp_issue_instr, q_fp.pop_front());
            end
        end
    end

    task automatic send(input logic [31:0] l, input logic [31:0] r);
        chk("R9", "ready before send", {31'd0, fetch_ready}, 32'd1);
        if (l[31:26] == FPOP) q_fp.push_back(l); else q_int.push_back(l);
        if (r[31:26] == FPOP) q_fp.push_back(r); else q_int.push_back(r);
        fetch_bundle = {r, l};
        fetch_valid  = 1'b1;
        @(posedge clk); #1;
        fetch_valid  = 1'b0;
    endtask

    task automatic wb2(input logic [4:0] a, input logic [4:0] b);
        int_wb_valid = 1'b1; int_wb_reg = a;
        fp_wb_valid  = 1'b1; fp_wb_reg  = b;
        @(posedge clk); #1;
        int_wb_valid = 1'b0; fp_wb_valid = 1'b0;
    endtask

    task automatic see(input string req, input logic iv, input logic fv, input logic rdy);
        chk(req, "int_issue_valid", {31'd0, int_issue_valid}, {31'd0, iv});
        chk(req, "fp_issue_valid",  {31'd0, fp_issue_valid},  {31'd0, fv});
        chk(req, "fetch_ready",     {31'd0, fetch_ready},     {31'd0, rdy});
    endtask

    logic [31:0] l, r, l2, r2;

    task automatic run_tests();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        see("R1", 1'b0, 1'b0, 1'b1);

        // R3: integer + FP pair issues together
        l = mk(6'h08, 5'd1, 5'd2, 5'd3); r = mk(FPOP, 5'd4, 5'd5, 5'd6);
        send(l, r); @(negedge clk);
        see("R3", 1'b1, 1'b1, 1'b1);
        chk("R3", "int instr", int_issue_instr, l);
        chk("R3", "fp instr", fp_issue_instr, r);

        // R7/R4/R10: left reads busy r1, stall; junk bundle ignored
        l = mk(6'h08, 5'd13, 5'd1, 5'd0); r = mk(FPOP, 5'd10, 5'd11, 5'd12);
        send(l, r); @(negedge clk);
        see("R4", 1'b0, 1'b0, 1'b0);
        fetch_bundle = {mk(6'h08, 5'd20, 5'd0, 5'd0), mk(6'h08, 5'd21, 5'd0, 5'd0)};
        fetch_valid = 1'b1;
        @(posedge clk); #1; fetch_valid = 1'b0;
        @(negedge clk);
        see("R7", 1'b0, 1'b0, 1'b0);
        wb2(5'd1, 5'd4); @(negedge clk);
        see("R7", 1'b1, 1'b1, 1'b1);
        chk("R10", "held left kept", int_issue_instr, l);
        chk("R10", "held right kept", fp_issue_instr, r);
        @(negedge clk);
        see("R10", 1'b0, 1'b0, 1'b1);
        wb2(5'd13, 5'd10); @(negedge clk);

        // R5: integer right slot (opcodes next to FP value) issues later
        l = mk(6'h10, 5'd14, 5'd0, 5'd0); r = mk(6'h12, 5'd15, 5'd0, 5'd0);
        send(l, r); @(negedge clk);
        see("R5", 1'b1, 1'b0, 1'b0);
        chk("R5", "left first", int_issue_instr, l);
        @(negedge clk);
        see("R5", 1'b1, 1'b0, 1'b1);
        chk("R5", "right later", int_issue_instr, r);
        wb2(5'd14, 5'd15); @(negedge clk);

        // R6: right reads left's destination
        l = mk(6'h08, 5'd7, 5'd0, 5'd0); r = mk(FPOP, 5'd16, 5'd7, 5'd0);
        send(l, r); @(negedge clk);
        see("R6", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        see("R7", 1'b0, 1'b0, 1'b0);
        wb2(5'd7, 5'd0); @(negedge clk);
        see("R6", 1'b0, 1'b1, 1'b1);
        chk("R6", "right after wb", fp_issue_instr, r);
        wb2(5'd0, 5'd16); @(negedge clk);

        // R8: register 0 never stalls, back-to-back bundles
        l = mk(6'h08, 5'd0, 5'd0, 5'd0); r = mk(FPOP, 5'd18, 5'd0, 5'd0);
        send(l, r); @(negedge clk);
        see("R8", 1'b1, 1'b1, 1'b1);
        l2 = mk(6'h08, 5'd19, 5'd0, 5'd0); r2 = mk(FPOP, 5'd0, 5'd0, 5'd0);
        send(l2, r2); @(negedge clk);
        see("R8", 1'b1, 1'b1, 1'b1);
        wb2(5'd19, 5'd18); @(negedge clk);

        // R2: FP instruction in the left slot goes to the FP pipe alone
        l = mk(FPOP, 5'd21, 5'd0, 5'd0); r = mk(FPOP, 5'd22, 5'd0, 5'd0);
        send(l, r); @(negedge clk);
        see("R2", 1'b0, 1'b1, 1'b0);
        chk("R2", "left fp on fp pipe", fp_issue_instr, l);
        @(negedge clk);
        see("R2", 1'b0, 1'b1, 1'b1);
        chk("R2", "right fp later", fp_issue_instr, r);
        wb2(5'd21, 5'd22); @(negedge clk);

        chk("R9", "int queue drained", q_int.size(), 0);
        chk("R9", "fp queue drained", q_fp.size(), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL R9 watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule